// File: doc/BRIEF.md
# Short branch resolver for a 16-bit instruction stream

The block looks at one 16-bit instruction per cycle, together with its address and the four condition flags (negative, zero, carry, overflow). It decides whether the instruction is a short relative branch and, if so, whether it is taken. It computes the destination address and raises a one-cycle pipeline flush when control flow changes.

Two encodings are handled. The conditional form carries a 4-bit condition and an 8-bit signed halfword offset. The unconditional form carries an 11-bit signed halfword offset. Inside the conditional form, two condition values are not branches. One value reports a software interrupt and passes its 8-bit immediate on. The other reports an undefined encoding.

All results are registered and appear one cycle after the instruction is presented. The surrounding pipeline owns fetch, flag generation and exception entry.

Top module: `branch_resolver`

## Requirements
- R1: An instruction with bits [15:12] = 1101 and a condition field [11:8] other than 1110 or 1111 is a conditional branch: branch_o is 1 in the result cycle.
- R2: Single-flag conditions. Code 0 is taken when Z=1 and code 1 when Z=0. Code 2 is taken when C=1 and code 3 when C=0. Code 4 is taken when N=1 and code 5 when N=0. Code 6 is taken when V=1 and code 7 when V=0.
- R3: Code 8 is taken when C=1 and Z=0. Code 9 is taken when C=0 or Z=1.
- R4: Code 10 is taken when N=V and code 11 when N!=V. Code 12 is taken when Z=0 and N=V. Code 13 is taken when Z=1 or N!=V.
- R5: A taken conditional branch drives target_o = address + 4 + (sign-extended bits [7:0] shifted left by one).
- R6: An instruction with bits [15:11] = 11100 is an unconditional branch. It is always taken, and target_o = address + 4 + (sign-extended bits [10:0] shifted left by one).
- R7: Condition field 1111 in the conditional form sets swi_o and copies bits [7:0] to swi_imm_o. branch_o, taken_o and flush_o stay 0.
- R8: Condition field 1110 in the conditional form sets undef_o. branch_o, taken_o, swi_o and flush_o stay 0.
- R9: A conditional branch whose condition fails sets branch_o, but taken_o and flush_o stay 0 and target_o reads 0.
- R10: Each taken branch produces exactly one flush_o pulse, in the cycle after valid_i, even when taken branches arrive back to back.
- R11: done_o follows valid_i one cycle later. Any other encoding, and any cycle without valid_i, leaves branch_o, taken_o, flush_o, swi_o, undef_o, swi_imm_o and target_o at 0.
- R12: While rst_ni is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| instr_i | input | 16 | Instruction halfword |
| pc_i | input | ADDR_W | Address of the instruction |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| flag_v_i | input | 1 | Overflow flag |
| done_o | output | 1 | Result valid |
| branch_o | output | 1 | Instruction was a branch (taken or not) |
| taken_o | output | 1 | Branch redirects control flow |
| flush_o | output | 1 | One-cycle pipeline flush |
| target_o | output | ADDR_W | Destination address when taken, else 0 |
| swi_o | output | 1 | Software interrupt encoding seen |
| swi_imm_o | output | 8 | Interrupt immediate |
| undef_o | output | 1 | Undefined encoding seen |

## Verification
Every result register is loaded from the current instruction alone, so a wrong decode, condition or offset shows up in the very next cycle, on taken_o, target_o or one of the class flags. A wrong condition mapping flips taken_o only for the flag patterns that tell two codes apart. For that reason, every code is driven with all sixteen flag combinations. Offsets are exercised at both signs and at both extremes, because a sign-extension slip shows only when the top offset bit is set. A flush that fails to clear, or that does not track taken_o, is visible by the cycle after the branch.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef enum logic [3:0] {
    CC_ZS = 4'd0,  CC_ZC = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
    CC_NS = 4'd4,  CC_NC = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
    CC_UGT = 4'd8, CC_ULE = 4'd9, CC_SGE = 4'd10, CC_SLT = 4'd11,
    CC_SGT = 4'd12, CC_SLE = 4'd13, CC_UDF = 4'd14, CC_SWI = 4'd15
  } cond_e;

  localparam logic [3:0] COND_FMT  = 4'b1101;
  localparam logic [4:0] UNCOND_FMT = 5'b11100;
  localparam int unsigned COND_OFF_W   = 8;
  localparam int unsigned UNCOND_OFF_W = 11;
endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
(
  input  cond_e  cond_i,
  input  flags_t flags_i,
  output logic   pass_o
);
  logic n_eq_v;
  assign n_eq_v = (flags_i.n == flags_i.v);

  always_comb begin
    unique case (cond_i)
      CC_ZS:  pass_o = flags_i.z;
      CC_ZC:  pass_o = !flags_i.z;
      CC_CS:  pass_o = flags_i.c;
      CC_CC:  pass_o = !flags_i.c;
      CC_NS:  pass_o = flags_i.n;
      CC_NC:  pass_o = !flags_i.n;
      CC_VS:  pass_o = flags_i.v;
      CC_VC:  pass_o = !flags_i.v;
      CC_UGT: pass_o = flags_i.c && !flags_i.z;
      CC_ULE: pass_o = !flags_i.c || flags_i.z;
      CC_SGE: pass_o = n_eq_v;
      CC_SLT: pass_o = !n_eq_v;
      CC_SGT: pass_o = !flags_i.z && n_eq_v;
      CC_SLE: pass_o = flags_i.z || !n_eq_v;
      default: pass_o = 1'b0;  // reserved codes never branch
    endcase
  end
endmodule

// File: rtl/br_target.sv
module br_target #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 8
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] target_o
);
  localparam int unsigned EXT_W = ADDR_W - OFF_W - 1;
  localparam logic [ADDR_W-1:0] PIPE_AHEAD = ADDR_W'(4);

  logic [ADDR_W-1:0] disp;
  assign disp = {{EXT_W{off_i[OFF_W-1]}}, off_i, 1'b0};
  assign target_o = pc_i + PIPE_AHEAD + disp;
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import br_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [15:0]       instr_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              flag_n_i,
  input  logic              flag_z_i,
  input  logic              flag_c_i,
  input  logic              flag_v_i,
  output logic              done_o,
  output logic              branch_o,
  output logic              taken_o,
  output logic              flush_o,
  output logic [ADDR_W-1:0] target_o,
  output logic              swi_o,
  output logic [7:0]        swi_imm_o,
  output logic              undef_o
);
  localparam int unsigned N_FMT = 2;

  flags_t flags;
  cond_e  cond;
  logic   pass;
  logic   is_cond_fmt, is_swi, is_udf, is_bcc, is_b, take_c, branch_c;
  logic [ADDR_W-1:0] tgt [N_FMT];
  logic [ADDR_W-1:0] tgt_c;

  assign flags = '{n: flag_n_i, z: flag_z_i, c: flag_c_i, v: flag_v_i};
  assign cond  = cond_e'(instr_i[11:8]);

  br_cond_eval u_cond (.cond_i(cond), .flags_i(flags), .pass_o(pass));

  for (genvar g = 0; g < N_FMT; g++) begin : g_tgt
    localparam int unsigned OW = (g == 0) ? COND_OFF_W : UNCOND_OFF_W;
    br_target #(.ADDR_W(ADDR_W), .OFF_W(OW)) u_tgt (
      .pc_i(pc_i), .off_i(instr_i[OW-1:0]), .target_o(tgt[g]));
  end

  assign is_cond_fmt = valid_i && (instr_i[15:12] == COND_FMT);
  assign is_swi   = is_cond_fmt && (cond == CC_SWI);
  assign is_udf   = is_cond_fmt && (cond == CC_UDF);
  assign is_bcc   = is_cond_fmt && !is_swi && !is_udf;
  assign is_b     = valid_i && (instr_i[15:11] == UNCOND_FMT);
  assign branch_c = is_bcc || is_b;
  assign take_c   = is_b || (is_bcc && pass);
  assign tgt_c    = is_b ? tgt[1] : tgt[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      branch_o  <= 1'b0;
      taken_o   <= 1'b0;
      flush_o   <= 1'b0;
      target_o  <= '0;
      swi_o     <= 1'b0;
      swi_imm_o <= '0;
      undef_o   <= 1'b0;
    end else begin
      done_o    <= valid_i;
      branch_o  <= branch_c;
      taken_o   <= take_c;
      flush_o   <= take_c;
      target_o  <= take_c ? tgt_c : '0;
      swi_o     <= is_swi;
      swi_imm_o <= is_swi ? instr_i[7:0] : '0;
      undef_o   <= is_udf;
    end
  end

  assert_taken_is_branch_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> branch_o);
  assert_swi_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swi_o |-> !branch_o && !taken_o && !flush_o && !undef_o);
  assert_udf_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> !branch_o && !taken_o && !flush_o && swi_imm_o == 8'd0);
  assert_flush_tracks_taken_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o == taken_o);
  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !(branch_o || swi_o || undef_o || flush_o));
  assert_target_parity_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> target_o[0] == $past(pc_i[0]));
endmodule

// File: tb/branch_resolver_test.sv
module branch_resolver_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        br, tk, fl, swi, udf;
    logic [7:0]  imm;
    logic [31:0] tgt;
  } exp_t;

  logic clk = 0, rst_n = 0, valid = 0;
  logic [15:0] instr = '0;
  logic [31:0] pc = '0;
  logic fn = 0, fz = 0, fc = 0, fv = 0;
  logic done, br, tk, fl, swi, udf;
  logic [7:0] imm;
  logic [31:0] tgt;

  exp_t  exp_q[$];
  string tag_q[$];
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_resolver #(.ADDR_W(32)) uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .instr_i(instr), .pc_i(pc),
    .flag_n_i(fn), .flag_z_i(fz), .flag_c_i(fc), .flag_v_i(fv),
    .done_o(done), .branch_o(br), .taken_o(tk), .flush_o(fl), .target_o(tgt),
    .swi_o(swi), .swi_imm_o(imm), .undef_o(udf));

  function automatic logic cond_ok(input logic [3:0] c, input logic n, z, cy, v);
    case (c)
      0: return z;        1: return !z;
      2: return cy;       3: return !cy;
      4: return n;        5: return !n;
      6: return v;        7: return !v;
      8: return cy && !z; 9: return !cy || z;
      10: return n == v;  11: return n != v;
      12: return !z && n == v;
      13: return z || n != v;
      default: return 0;
    endcase
  endfunction

  function automatic string cond_tag(input logic [3:0] c);
    if (c < 8) return "R2";
    if (c < 10) return "R3";
    return "R4";
  endfunction

  task automatic check(input string tag, input exp_t a, input exp_t e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  // driver: present one instruction, push expected result
  task automatic drive(input logic [15:0] ins, input logic [31:0] addr,
                       input logic [3:0] nzcv, input string tag);
    exp_t e;
    logic [3:0] c;
    logic ok;
    e = '0;
    c = ins[11:8];
    if (ins[15:12] == 4'b1101) begin
      if (c == 4'hF) begin e.swi = 1; e.imm = ins[7:0]; end
      else if (c == 4'hE) e.udf = 1;
      else begin
        ok = cond_ok(c, nzcv[3], nzcv[2], nzcv[1], nzcv[0]);
        e.br = 1; e.tk = ok; e.fl = ok;
        if (ok) e.tgt = addr + 32'd4 + {{23{ins[7]}}, ins[7:0], 1'b0};
      end
    end else if (ins[15:11] == 5'b11100) begin
      e.br = 1; e.tk = 1; e.fl = 1;
      e.tgt = addr + 32'd4 + {{20{ins[10]}}, ins[10:0], 1'b0};
    end
    @(negedge clk);
    valid = 1; instr = ins; pc = addr;
    {fn, fz, fc, fv} = nzcv;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = 0;
      instr = 16'hD0FF;  // would be a branch if valid
    end
  endtask

  // monitor: compare every result cycle against the queue
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      exp_t a;
      a = '{br: br, tk: tk, fl: fl, swi: swi, udf: udf, imm: imm, tgt: tgt};
      if (done) begin
        if (exp_q.size() == 0) check("R11 spurious", a, '1);
        else check(tag_q.pop_front(), a, exp_q.pop_front());
      end else if (a != '0) check("R11 idle", a, '0);
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    exp_t z;
    z = '0;
    #(CLK_PERIOD * 2 + 1);
    check("R12 reset", '{br: br, tk: tk, fl: fl, swi: swi, udf: udf, imm: imm, tgt: tgt}, z);
    checks++;
    if (done !== 1'b0) begin fails++; $display("FAIL R12 done=%b expected=0", done); end
    @(negedge clk);
    rst_n = 1;
    idle(2);

    // R1 R2 R3 R4 R9: every condition against every flag pattern
    for (int c = 0; c < 14; c++)
      for (int f = 0; f < 16; f++)
        drive({4'b1101, 4'(c), 8'h10 + 8'(f)}, 32'h0000_1000 + 32'(c*64), 4'(f),
              cond_tag(4'(c)));

    // R5: offset extremes and signs
    drive(16'hD07F, 32'h0000_2000, 4'b0100, "R5 max fwd");
    drive(16'hD080, 32'h0000_2000, 4'b0100, "R5 max back");
    drive(16'hD0FF, 32'h0000_0000, 4'b0100, "R5 wrap");
    drive(16'hD100, 32'h0000_3002, 4'b0000, "R5 zero off");
    // R9: failed condition gives no redirect
    drive(16'hD040, 32'h0000_4000, 4'b0000, "R9 not taken");
    // R6: unconditional branch, both signs
    drive(16'hE3FF, 32'h0001_0000, 4'b0000, "R6 max fwd");
    drive(16'hE400, 32'h0001_0000, 4'b1111, "R6 max back");
    drive(16'hE7FF, 32'h0000_0010, 4'b0101, "R6 minus one");
    // R7 R8
    drive(16'hDFAB, 32'h0000_5000, 4'b1111, "R7 swi");
    drive(16'hDF00, 32'h0000_5000, 4'b0000, "R7 swi zero");
    drive(16'hDE12, 32'h0000_6000, 4'b1111, "R8 undef");
    // R11: other encodings
    drive(16'hE800, 32'h0000_7000, 4'b1111, "R11 other fmt");
    drive(16'hC0FF, 32'h0000_7000, 4'b0100, "R11 other fmt");
    drive(16'h0000, 32'h0000_7000, 4'b0100, "R11 zero word");
    // R10: back-to-back taken branches each flush
    drive(16'hE001, 32'h0000_8000, 4'b0000, "R10 b2b a");
    drive(16'hE002, 32'h0000_8002, 4'b0000, "R10 b2b b");
    drive(16'hD003, 32'h0000_8004, 4'b0100, "R10 b2b c");
    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R11 pending=%0d expected=0", exp_q.size());
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule